// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDRAM array from its power-up state to normal operation. A start pulse makes it issue a fixed series of initialization commands on a command port. Each command uses a valid/ready handshake. A programmable quiet gap follows each accepted command, so that precharge and refresh recovery times are covered. The series is:

1. one precharge-all-banks command;
2. a fixed number of auto-refresh commands, eight by default;
3. one mode-register write, which carries a programmable mode value.

When the quiet gap after the mode write has elapsed, the block declares initialization complete. In that same step it enables a periodic refresh generator.

The refresh generator has two stages. A prescaler divides the clock by `cfg_prescale + 1`. A refresh timer counts `cfg_rtimer + 1` prescaled ticks. Each time the timer expires, it raises a sticky refresh request. The surrounding memory controller services the request and acknowledges it. The timer reloads on expiry, so the request period stays a constant `(cfg_prescale+1)*(cfg_rtimer+1)` clock cycles.

Top module: `sdram_bringup_seq`

## Requirements
- R1: After the asynchronous reset, `cmd_valid`, `cmd_op`, `init_done` and `refresh_req` are all low, and the block waits idle for a start pulse.
- R2: A `start` pulse in the idle state makes `cmd_valid` rise in the next cycle. The first command is precharge-all, with `cmd_op` = 1.
- R3: After the precharge come exactly NUM_REFRESH (default 8) auto-refresh commands (`cmd_op` = 2). Then comes one mode-register write (`cmd_op` = 3), which carries `mode_value` on `cmd_mode`. While `cmd_valid` is high, `cmd_op` is never 0.
- R4: A command stays on the port with `cmd_valid` high and `cmd_op` unchanged until a cycle in which `cmd_ready` is high. The next command is not presented before that handshake.
- R5: Between the handshake cycle of one command and the first valid cycle of the next, there are exactly `cfg_gap` cycles with `cmd_valid` low.
- R6: `init_done` rises `cfg_gap`+1 cycles after the handshake of the mode-register write. It then stays high, and no further command is presented.
- R7: `refresh_req` is never high while `init_done` is low.
- R8: `refresh_req` first rises exactly N = (`cfg_prescale`+1)*(`cfg_rtimer`+1) cycles after the first cycle of `init_done`. It expires again every N cycles after that, without drift.
- R9: `refresh_req` stays high until a cycle with `refresh_ack` high. It is low in the following cycle, unless the timer expires in the acknowledge cycle, in which case it stays high.
- R10: A `start` pulse while the sequence is running or after `init_done` has no effect on the command series, `init_done` or the refresh timing.
- R11: `soft_clr` high makes `cmd_valid`, `init_done` and `refresh_req` low in the next cycle and returns the block to idle. A later `start` then runs the full series again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous return to idle, refresh disabled |
| start | input | 1 | Begin the initialization series (accepted only in idle) |
| cfg_gap | input | GAP_W | Idle cycles enforced after each accepted command |
| cfg_prescale | input | PRE_W | Prescaler divide value minus one |
| cfg_rtimer | input | RT_W | Prescaled ticks per refresh interval minus one |
| mode_value | input | MODE_W | Value loaded by the mode-register write |
| cmd_valid | output | 1 | Command present on the port |
| cmd_ready | input | 1 | Command accepted this cycle |
| cmd_op | output | 2 | Command code: 0 none, 1 precharge-all, 2 auto-refresh, 3 mode write |
| cmd_mode | output | MODE_W | Mode value during a mode write, zero otherwise |
| init_done | output | 1 | Normal operation entered, refresh enabled |
| refresh_req | output | 1 | Sticky periodic refresh request |
| refresh_ack | input | 1 | Clears the refresh request |

## Verification
A wrong step counter shows up in the command stream itself. It appears as a wrong `cmd_op` value or a wrong number of refreshes, visible at the first command after the fault. A wrong gap count changes the number of idle cycles before the very next valid. A fault in either stage of the refresh timer moves the first `refresh_req` edge, or a later one, away from its computed cycle. So it is caught within one refresh interval after `init_done`. A lost sticky bit, or an acknowledge that does not clear, is seen one cycle after the acknowledge or the expiry.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP           = 2'd0,
    OP_PRECHARGE_ALL = 2'd1,
    OP_AUTO_REFRESH  = 2'd2,
    OP_MODE_WRITE    = 2'd3
  } sdr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_GAP   = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

  // Step 0 precharges, steps 1..n_ref refresh, the step after writes the mode.
  function automatic sdr_op_e op_for_step(input int unsigned step,
                                          input int unsigned n_ref);
    if (step == 0)          return OP_PRECHARGE_ALL;
    else if (step <= n_ref) return OP_AUTO_REFRESH;
    else                    return OP_MODE_WRITE;
  endfunction

endpackage

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
  import sdr_seq_pkg::*;
#(
  parameter int NUM_REFRESH = 8,
  parameter int GAP_W       = 4,
  parameter int MODE_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              start,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [MODE_W-1:0] mode_value,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [MODE_W-1:0] cmd_mode,
  output logic              run_en
);

  localparam int STEPS  = NUM_REFRESH + 2;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  seq_state_e        state_q, state_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [GAP_W-1:0]  gap_q, gap_n;
  logic              advance;
  sdr_op_e           cur_op;

  assign cur_op = op_for_step(32'(step_q), NUM_REFRESH);

  always_comb begin
    advance = 1'b0;
    if (state_q == ST_ISSUE && cmd_ready && cfg_gap == '0) advance = 1'b1;
    if (state_q == ST_GAP && gap_q <= GAP_W'(1))           advance = 1'b1;
  end

  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    gap_n   = gap_q;
    if (soft_clr) begin
      state_n = ST_IDLE;
      step_n  = '0;
      gap_n   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_n = ST_ISSUE;
            step_n  = '0;
          end
        end
        ST_ISSUE: begin
          if (cmd_ready && cfg_gap != '0) begin
            state_n = ST_GAP;
            gap_n   = cfg_gap;
          end
        end
        ST_GAP: begin
          if (!advance) gap_n = gap_q - 1'b1;
        end
        ST_RUN: state_n = ST_RUN;
        default: state_n = ST_IDLE;
      endcase
      if (advance) begin
        gap_n = '0;
        if (step_q == LAST_STEP) begin
          state_n = ST_RUN;
        end else begin
          state_n = ST_ISSUE;
          step_n  = step_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      gap_q   <= gap_n;
    end
  end

  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_op    = cmd_valid ? cur_op : OP_NOP;
  assign cmd_mode  = (cmd_valid && cur_op == OP_MODE_WRITE) ? mode_value : '0;
  assign run_en    = (state_q == ST_RUN);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int PRE_W = 4,
  parameter int RT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [RT_W-1:0]  cfg_rtimer,
  input  logic             refresh_ack,
  output logic             refresh_req
);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [RT_W-1:0]  rt_q, rt_n;
  logic             req_q, req_n;
  logic             tick, expire;

  assign tick   = enable && (pre_q == cfg_prescale);
  assign expire = tick && (rt_q == cfg_rtimer);

  always_comb begin
    if (!enable) begin
      pre_n = '0;
      rt_n  = '0;
      req_n = 1'b0;
    end else begin
      pre_n = tick ? '0 : pre_q + 1'b1;
      if (expire)    rt_n = '0;
      else if (tick) rt_n = rt_q + 1'b1;
      else           rt_n = rt_q;
      req_n = expire | (req_q & ~refresh_ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rt_q  <= '0;
      req_q <= 1'b0;
    end else begin
      pre_q <= pre_n;
      rt_q  <= rt_n;
      req_q <= req_n;
    end
  end

  assign refresh_req = req_q;

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq #(
  parameter int NUM_REFRESH = 8,
  parameter int GAP_W       = 4,
  parameter int PRE_W       = 4,
  parameter int RT_W        = 4,
  parameter int MODE_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              start,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [RT_W-1:0]   cfg_rtimer,
  input  logic [MODE_W-1:0] mode_value,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [MODE_W-1:0] cmd_mode,
  output logic              init_done,
  output logic              refresh_req,
  input  logic              refresh_ack
);

  logic run_en;
  logic timer_en;

  sdr_init_fsm #(
    .NUM_REFRESH(NUM_REFRESH),
    .GAP_W      (GAP_W),
    .MODE_W     (MODE_W)
  ) init_fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .start     (start),
    .cfg_gap   (cfg_gap),
    .mode_value(mode_value),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_mode  (cmd_mode),
    .run_en    (run_en)
  );

  assign timer_en = run_en && !soft_clr;

  sdr_refresh_timer #(
    .PRE_W(PRE_W),
    .RT_W (RT_W)
  ) refresh_timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (timer_en),
    .cfg_prescale(cfg_prescale),
    .cfg_rtimer  (cfg_rtimer),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req)
  );

  assign init_done = run_en;

endmodule

// File: rtl/sdram_bringup_seq_chk.sv
module sdram_bringup_seq_chk #(
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_clr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [MODE_W-1:0] cmd_mode,
  input logic              init_done,
  input logic              refresh_req,
  input logic              refresh_ack
);

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !soft_clr) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_mode))); // R4

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 2'd0)); // R3

  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !soft_clr) |=> init_done); // R6

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_valid); // R6

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack && !soft_clr) |=> refresh_req); // R9

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!cmd_valid && !init_done && !refresh_req)); // R11

endmodule

bind sdram_bringup_seq sdram_bringup_seq_chk #(.MODE_W(MODE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_clr   (soft_clr),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_mode   (cmd_mode),
  .init_done  (init_done),
  .refresh_req(refresh_req),
  .refresh_ack(refresh_ack)
);

// File: tb/sdram_bringup_seq_tb_top.sv
module sdram_bringup_seq_tb_top;

  localparam int NREF   = 8;
  localparam int GAP_W  = 4;
  localparam int PRE_W  = 4;
  localparam int RT_W   = 4;
  localparam int MODE_W = 12;

  logic              clk;
  logic              rst_n;
  logic              soft_clr;
  logic              start;
  logic [GAP_W-1:0]  cfg_gap;
  logic [PRE_W-1:0]  cfg_prescale;
  logic [RT_W-1:0]   cfg_rtimer;
  logic [MODE_W-1:0] mode_value;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [1:0]        cmd_op;
  logic [MODE_W-1:0] cmd_mode;
  logic              init_done;
  logic              refresh_req;
  logic              refresh_ack;

  int n_checks = 0;
  int n_fails  = 0;

  sdram_bringup_seq #(
    .NUM_REFRESH(NREF), .GAP_W(GAP_W), .PRE_W(PRE_W), .RT_W(RT_W), .MODE_W(MODE_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .start(start),
    .cfg_gap(cfg_gap), .cfg_prescale(cfg_prescale), .cfg_rtimer(cfg_rtimer),
    .mode_value(mode_value), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mode(cmd_mode), .init_done(init_done),
    .refresh_req(refresh_req), .refresh_ack(refresh_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  task automatic run_cfg(input int g, input int p, input int t, input int d);
    int lows;
    int cnt;
    int n_int;
    int exp_op;
    logic [MODE_W-1:0] mv;
    mv = MODE_W'(g * 256 + p * 16 + t + 1);
    n_int = (p + 1) * (t + 1);
    @(negedge clk);
    soft_clr = 1'b1;
    cfg_gap = GAP_W'(g); cfg_prescale = PRE_W'(p); cfg_rtimer = RT_W'(t);
    mode_value = mv;
    @(negedge clk);
    soft_clr = 1'b0;
    // R11: cleared to idle
    check(!cmd_valid && !init_done && !refresh_req, "R11",
          int'({cmd_valid, init_done, refresh_req}), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NREF + 2; k++) begin
      exp_op = (k == 0) ? 1 : ((k <= NREF) ? 2 : 3);
      check(cmd_valid, "R4", int'(cmd_valid), 1);
      check(int'(cmd_op) == exp_op, (k == 0) ? "R2" : "R3", int'(cmd_op), exp_op);
      if (k == NREF + 1) check(cmd_mode == mv, "R3", int'(cmd_mode), int'(mv));
      for (int w = 0; w < d; w++) begin
        if (k == 3) start = 1'b1;  // R10: ignored mid-series
        @(negedge clk);
        start = 1'b0;
        check(cmd_valid && int'(cmd_op) == exp_op, "R4", int'(cmd_op), exp_op);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      lows = 0;
      while (!cmd_valid && !init_done && lows < 40) begin
        if (refresh_req) check(1'b0, "R7", 1, 0);
        lows++;
        @(negedge clk);
      end
      check(lows == g, (k == NREF + 1) ? "R6" : "R5", lows, g);
      if (k == NREF + 1)
        check(init_done && !cmd_valid, "R6", int'({init_done, cmd_valid}), 2);
    end
    // at first cycle of init_done
    cnt = 0;
    while (!refresh_req && cnt < 600) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == n_int, "R8", cnt, n_int);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check(refresh_req == (n_int == 1), "R9", int'(refresh_req), int'(n_int == 1));
    cnt = 0;
    while (!refresh_req && cnt < 600) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == n_int - 1, "R8", cnt, n_int - 1);
    // no acknowledge: request must hold; a start here must be ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 1; w < n_int; w++) @(negedge clk);
    check(refresh_req, "R9", int'(refresh_req), 1);
    check(init_done && !cmd_valid, "R10", int'({init_done, cmd_valid}), 2);
    // R11: clear from normal operation
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    check(!cmd_valid && !init_done && !refresh_req, "R11",
          int'({cmd_valid, init_done, refresh_req}), 0);
  endtask

  initial begin
    rst_n = 1'b0; soft_clr = 1'b0; start = 1'b0; cmd_ready = 1'b0; refresh_ack = 1'b0;
    cfg_gap = '0; cfg_prescale = '0; cfg_rtimer = '0; mode_value = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!cmd_valid && cmd_op == 2'd0 && !init_done && !refresh_req, "R1",
          int'({cmd_valid, cmd_op, init_done, refresh_req}), 0);
    repeat (3) @(negedge clk);
    check(!cmd_valid && !init_done, "R1", int'({cmd_valid, init_done}), 0);
    for (int g = 0; g < 3; g++)
      for (int p = 0; p < 3; p++)
        for (int t = 0; t < 3; t++)
          for (int d = 0; d < 2; d++)
            run_cfg(g, p, t, d);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule